// File: doc/BRIEF.md
# Flash Command Interface Decoder

This block sits between the host side of a 16-bit NOR flash bus and the internal program/erase controller. Every bus write cycle is turned into one write event. The low data byte of the event is read as a command. The block follows multi-cycle sequences: a set-up byte followed by a confirm byte, or a set-up byte followed by one or two address/data words. It keeps a read mode that tells the surrounding read path which source to place on the bus: the array, the status register, the electronic signature or the query table.

Finished sequences become one-cycle request pulses to the program/erase controller, carrying the latched address and data. The controller returns a busy flag and a suspended flag. These decide which commands the decoder accepts. While the controller is busy, reads are forced to the status register. A command sequence that is not valid in idle mode sends the interface back to array read mode. A command that is not allowed in the current busy or suspended state is dropped and changes nothing.

Top module: `flash_cmd_decoder`

## Requirements
- R1: A write event happens once for each assertion of the combined strobe (ce_n low, we_n low, oe_n high), on the first clock that sees the strobe active. The command is wdata[7:0]. A cycle with oe_n low is not a write and changes nothing.
- R2: In idle, with the controller neither busy nor suspended, command FFh sets rd_sel to 0 (array), 70h sets 1 (status), 90h sets 2 (signature) and 98h sets 3 (query).
- R3: With rd_sel = 2, aux_word is {8'h00, MFR_CODE} when addr[0] = 0 and {8'h00, DEV_CODE} when addr[0] = 1.
- R4: The pair 20h then D0h pulses req_erase for one cycle, with req_addr equal to the address of the second write, and sets the read mode to status.
- R5: The pair 20h followed by any byte other than D0h sets status bits 5 and 4, issues no request and selects array mode. A later 50h clears both bits.
- R6: 40h or 10h followed by a write pulses req_prog with req_addr and req_data taken from that second write. At most one request pulse is high in any cycle.
- R7: 30h followed by two writes pulses req_dprog with the first word on req_addr/req_data and the second on req_addr2/req_data2, but only if the two addresses differ in bit 0 alone. Any other pair issues nothing and selects array mode.
- R8: While pe_busy is high, rd_sel reads 1. Only 70h and B0h are accepted, and B0h pulses req_suspend. Every other command is dropped, and the read mode held before it is still in force once busy falls.
- R9: While suspended and not busy, D0h pulses req_resume, and FFh, 70h, 90h and 98h select their modes. Program set-up is accepted only if the suspended operation is an erase. All other commands are dropped.
- R10: Any other byte, including B0h and D0h, written in idle while the controller is neither busy nor suspended selects array mode.
- R11: While rst_n is low, the read mode returns to array and any partly entered sequence is discarded.
- R12: status_byte bit 7 is the inverse of pe_busy. Bit 6 shows a suspended erase and bit 2 a suspended program. Bits 5 and 4 are the error flags. Bits 3, 1 and 0 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous clear |
| ce_n | input | 1 | Active-low chip enable |
| we_n | input | 1 | Active-low write enable |
| oe_n | input | 1 | Active-low output enable |
| addr | input | AW | Bus address |
| wdata | input | DW | Bus write data, command in the low byte |
| pe_busy | input | 1 | Controller is running an operation |
| pe_suspended | input | 1 | Controller holds a suspended operation |
| req_prog | output | 1 | Single-word program request pulse |
| req_dprog | output | 1 | Double-word program request pulse |
| req_erase | output | 1 | Block erase request pulse |
| req_suspend | output | 1 | Suspend request pulse |
| req_resume | output | 1 | Resume request pulse |
| req_addr | output | AW | Address of the request (first word) |
| req_data | output | DW | Data of the request (first word) |
| req_addr2 | output | AW | Second word address for double-word program |
| req_data2 | output | DW | Second word data for double-word program |
| rd_sel | output | 2 | Read source: 0 array, 1 status, 2 signature, 3 query |
| status_byte | output | 8 | Status register value |
| aux_word | output | DW | Status or signature word for the read path |

## Verification
The assertions assume that the bus inputs are synchronous to clk and stay stable for at least one whole clock while the strobe is active. They also assume that pe_busy and pe_suspended change only when the controller would legally change them, for example busy only after a request. The bench drives the bus and the controller flags on the falling clock edge only. Each write holds the strobe for exactly one clock and then releases it for a clock. The controller flags are moved by hand, only between writes and in the order a real controller would follow.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

    typedef enum logic [1:0] {
        RS_ARRAY  = 2'd0,
        RS_STATUS = 2'd1,
        RS_SIG    = 2'd2,
        RS_QUERY  = 2'd3
    } rsel_t;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_ERASE,
        SQ_PROG,
        SQ_DW1,
        SQ_DW2
    } seq_t;

    typedef enum logic [3:0] {
        CMD_RD_ARRAY,
        CMD_RD_STATUS,
        CMD_RD_SIG,
        CMD_RD_QUERY,
        CMD_CLEAR,
        CMD_ERASE_SETUP,
        CMD_PROG_SETUP,
        CMD_DPROG_SETUP,
        CMD_SUSPEND,
        CMD_CONFIRM,
        CMD_INVALID
    } cmd_t;

    typedef enum logic {
        OP_PROG  = 1'b0,
        OP_ERASE = 1'b1
    } op_t;

    localparam logic [7:0] BYTE_RD_ARRAY   = 8'hFF;
    localparam logic [7:0] BYTE_RD_STATUS  = 8'h70;
    localparam logic [7:0] BYTE_RD_SIG     = 8'h90;
    localparam logic [7:0] BYTE_RD_QUERY   = 8'h98;
    localparam logic [7:0] BYTE_CLEAR      = 8'h50;
    localparam logic [7:0] BYTE_ERASE      = 8'h20;
    localparam logic [7:0] BYTE_PROG_A     = 8'h40;
    localparam logic [7:0] BYTE_PROG_B     = 8'h10;
    localparam logic [7:0] BYTE_DPROG      = 8'h30;
    localparam logic [7:0] BYTE_SUSPEND    = 8'hB0;
    localparam logic [7:0] BYTE_CONFIRM    = 8'hD0;

endpackage

// File: rtl/fcd_strobe.sv
module fcd_strobe #(
    parameter int AW = 20,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic          ev,
    output logic [AW-1:0] ev_addr,
    output logic [DW-1:0] ev_data
);

    logic strobe_now;
    logic strobe_d, strobe_q;

    always_comb begin
        strobe_now = ~ce_n & ~we_n & oe_n;
        strobe_d   = strobe_now;
        ev         = strobe_now & ~strobe_q;
        ev_addr    = addr;
        ev_data    = wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) strobe_q <= 1'b0;
        else        strobe_q <= strobe_d;
    end

    // R1: a single event per strobe assertion
    assert_single_event_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ev |=> !ev);

endmodule

// File: rtl/fcd_classify.sv
module fcd_classify
    import fcd_pkg::*;
(
    input  logic [7:0] cmd_byte,
    output cmd_t       cmd
);

    always_comb begin
        unique case (cmd_byte)
            BYTE_RD_ARRAY:            cmd = CMD_RD_ARRAY;
            BYTE_RD_STATUS:           cmd = CMD_RD_STATUS;
            BYTE_RD_SIG:              cmd = CMD_RD_SIG;
            BYTE_RD_QUERY:            cmd = CMD_RD_QUERY;
            BYTE_CLEAR:               cmd = CMD_CLEAR;
            BYTE_ERASE:               cmd = CMD_ERASE_SETUP;
            BYTE_PROG_A, BYTE_PROG_B: cmd = CMD_PROG_SETUP;
            BYTE_DPROG:               cmd = CMD_DPROG_SETUP;
            BYTE_SUSPEND:             cmd = CMD_SUSPEND;
            BYTE_CONFIRM:             cmd = CMD_CONFIRM;
            default:                  cmd = CMD_INVALID;
        endcase
    end

endmodule

// File: rtl/fcd_status.sv
module fcd_status (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_err,
    input  logic       clr_err,
    input  logic       pe_busy,
    input  logic       erase_susp,
    input  logic       prog_susp,
    output logic [7:0] status_byte
);

    typedef struct packed {
        logic erase_err;
        logic prog_err;
    } err_t;

    err_t err_d, err_q;

    always_comb begin
        err_d = err_q;
        if (clr_err) begin
            err_d.erase_err = 1'b0;
            err_d.prog_err  = 1'b0;
        end
        if (set_err) begin
            err_d.erase_err = 1'b1;
            err_d.prog_err  = 1'b1;
        end
        status_byte = {~pe_busy, erase_susp, err_q.erase_err, err_q.prog_err,
                       1'b0, prog_susp, 1'b0, 1'b0};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= err_d;
    end

    // R5: a refused confirm raises both error bits
    assert_err_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        set_err |=> (status_byte[5:4] == 2'b11));

    // R5: clearing drops both error bits
    assert_err_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_err && !set_err) |=> (status_byte[5:4] == 2'b00));

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int         AW       = 20,
    parameter int         DW       = 16,
    parameter logic [7:0] MFR_CODE = 8'h20,
    parameter logic [7:0] DEV_CODE = 8'hC4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n,
    input  logic          we_n,
    input  logic          oe_n,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          pe_busy,
    input  logic          pe_suspended,
    output logic          req_prog,
    output logic          req_dprog,
    output logic          req_erase,
    output logic          req_suspend,
    output logic          req_resume,
    output logic [AW-1:0] req_addr,
    output logic [DW-1:0] req_data,
    output logic [AW-1:0] req_addr2,
    output logic [DW-1:0] req_data2,
    output logic [1:0]    rd_sel,
    output logic [7:0]    status_byte,
    output logic [DW-1:0] aux_word
);

    localparam int PAD = DW - 8;

    typedef struct packed {
        seq_t          seq;
        rsel_t         mode;
        op_t           act;
        op_t           skind;
        logic [AW-1:0] a1;
        logic [DW-1:0] d1;
        logic          r_prog;
        logic          r_dprog;
        logic          r_erase;
        logic          r_susp;
        logic          r_res;
        logic [AW-1:0] ra;
        logic [DW-1:0] rd;
        logic [AW-1:0] ra2;
        logic [DW-1:0] rd2;
    } st_t;

    st_t st_d, st_q;

    logic          ev;
    logic [AW-1:0] ev_addr;
    logic [DW-1:0] ev_data;
    cmd_t          cmd;
    logic          set_err, clr_err;
    logic          erase_susp, prog_susp;
    rsel_t         rsel_eff;

    fcd_strobe #(.AW(AW), .DW(DW)) u_strobe (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .we_n    (we_n),
        .oe_n    (oe_n),
        .addr    (addr),
        .wdata   (wdata),
        .ev      (ev),
        .ev_addr (ev_addr),
        .ev_data (ev_data)
    );

    fcd_classify u_classify (
        .cmd_byte (ev_data[7:0]),
        .cmd      (cmd)
    );

    always_comb begin
        st_d         = st_q;
        st_d.r_prog  = 1'b0;
        st_d.r_dprog = 1'b0;
        st_d.r_erase = 1'b0;
        st_d.r_susp  = 1'b0;
        st_d.r_res   = 1'b0;
        set_err      = 1'b0;
        clr_err      = 1'b0;

        if (ev) begin
            if (st_q.seq != SQ_IDLE) begin
                st_d.seq = SQ_IDLE;
                case (st_q.seq)
                    SQ_ERASE: begin
                        if (cmd == CMD_CONFIRM) begin
                            st_d.r_erase = 1'b1;
                            st_d.ra      = ev_addr;
                            st_d.act     = OP_ERASE;
                            st_d.mode    = RS_STATUS;
                        end else begin
                            set_err   = 1'b1;
                            st_d.mode = RS_ARRAY;
                        end
                    end
                    SQ_PROG: begin
                        st_d.r_prog = 1'b1;
                        st_d.ra     = ev_addr;
                        st_d.rd     = ev_data;
                        st_d.act    = OP_PROG;
                        st_d.mode   = RS_STATUS;
                    end
                    SQ_DW1: begin
                        st_d.a1  = ev_addr;
                        st_d.d1  = ev_data;
                        st_d.seq = SQ_DW2;
                    end
                    SQ_DW2: begin
                        if ((ev_addr ^ st_q.a1) == AW'(1)) begin
                            st_d.r_dprog = 1'b1;
                            st_d.ra      = st_q.a1;
                            st_d.rd      = st_q.d1;
                            st_d.ra2     = ev_addr;
                            st_d.rd2     = ev_data;
                            st_d.act     = OP_PROG;
                            st_d.mode    = RS_STATUS;
                        end else begin
                            st_d.mode = RS_ARRAY;
                        end
                    end
                    default: st_d.mode = RS_ARRAY;
                endcase
            end else if (pe_busy) begin
                if (cmd == CMD_RD_STATUS) begin
                    st_d.mode = RS_STATUS;
                end else if (cmd == CMD_SUSPEND) begin
                    st_d.r_susp = 1'b1;
                    st_d.skind  = st_q.act;
                    st_d.mode   = RS_STATUS;
                end
            end else if (pe_suspended) begin
                case (cmd)
                    CMD_RD_ARRAY:  st_d.mode = RS_ARRAY;
                    CMD_RD_STATUS: st_d.mode = RS_STATUS;
                    CMD_RD_SIG:    st_d.mode = RS_SIG;
                    CMD_RD_QUERY:  st_d.mode = RS_QUERY;
                    CMD_CONFIRM: begin
                        st_d.r_res = 1'b1;
                        st_d.act   = st_q.skind;
                        st_d.mode  = RS_STATUS;
                    end
                    CMD_PROG_SETUP: begin
                        if (st_q.skind == OP_ERASE) st_d.seq = SQ_PROG;
                    end
                    default: ;
                endcase
            end else begin
                case (cmd)
                    CMD_RD_ARRAY:    st_d.mode = RS_ARRAY;
                    CMD_RD_STATUS:   st_d.mode = RS_STATUS;
                    CMD_RD_SIG:      st_d.mode = RS_SIG;
                    CMD_RD_QUERY:    st_d.mode = RS_QUERY;
                    CMD_CLEAR:       clr_err   = 1'b1;
                    CMD_ERASE_SETUP: st_d.seq  = SQ_ERASE;
                    CMD_PROG_SETUP:  st_d.seq  = SQ_PROG;
                    CMD_DPROG_SETUP: st_d.seq  = SQ_DW1;
                    default:         st_d.mode = RS_ARRAY;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= '0;
            st_q.seq   <= SQ_IDLE;
            st_q.mode  <= RS_ARRAY;
            st_q.act   <= OP_PROG;
            st_q.skind <= OP_PROG;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        erase_susp = pe_suspended & (st_q.skind == OP_ERASE);
        prog_susp  = pe_suspended & (st_q.skind == OP_PROG);
        rsel_eff   = pe_busy ? RS_STATUS : st_q.mode;
    end

    fcd_status u_status (
        .clk         (clk),
        .rst_n       (rst_n),
        .set_err     (set_err),
        .clr_err     (clr_err),
        .pe_busy     (pe_busy),
        .erase_susp  (erase_susp),
        .prog_susp   (prog_susp),
        .status_byte (status_byte)
    );

    always_comb begin
        req_prog    = st_q.r_prog;
        req_dprog   = st_q.r_dprog;
        req_erase   = st_q.r_erase;
        req_suspend = st_q.r_susp;
        req_resume  = st_q.r_res;
        req_addr    = st_q.ra;
        req_data    = st_q.rd;
        req_addr2   = st_q.ra2;
        req_data2   = st_q.rd2;
        rd_sel      = rsel_eff;
        case (rsel_eff)
            RS_STATUS: aux_word = {{PAD{1'b0}}, status_byte};
            RS_SIG:    aux_word = {{PAD{1'b0}}, (addr[0] ? DEV_CODE : MFR_CODE)};
            default:   aux_word = '0;
        endcase
    end

    // R6: requests never overlap
    assert_one_request_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({req_prog, req_dprog, req_erase, req_suspend, req_resume}));

    // R4: an erase request always follows a write event
    assert_erase_after_event_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_erase) |-> $past(ev));

    // R7: the two words of a pair differ only in address bit 0
    assert_dword_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_dprog |-> ((req_addr ^ req_addr2) == AW'(1)));

    // R8: a refused command while busy leaves the read mode alone
    assert_busy_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (ev && pe_busy && st_q.seq == SQ_IDLE && cmd != CMD_RD_STATUS && cmd != CMD_SUSPEND)
        |=> (st_q.mode == $past(st_q.mode)));

    // R11: clear returns to array mode with no sequence pending
    assert_reset_array_R11: assert property (@(posedge clk)
        !rst_n |=> (st_q.mode == RS_ARRAY && st_q.seq == SQ_IDLE));

endmodule

// File: tb/flash_cmd_decoder_test.sv
`timescale 1ns/1ps
module flash_cmd_decoder_test;

    localparam int AW = 20;
    localparam int DW = 16;
    localparam logic [7:0] MFR = 8'h20;
    localparam logic [7:0] DEV = 8'hC4;

    localparam int SEL_RDSEL  = 0;
    localparam int SEL_STAT   = 1;
    localparam int SEL_AUX    = 2;
    localparam int SEL_NPROG  = 3;
    localparam int SEL_NDPROG = 4;
    localparam int SEL_NERASE = 5;
    localparam int SEL_NSUSP  = 6;
    localparam int SEL_NRES   = 7;
    localparam int SEL_ADDR   = 8;
    localparam int SEL_DATA   = 9;
    localparam int SEL_ADDR2  = 10;
    localparam int SEL_DATA2  = 11;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic pe_busy = 1'b0, pe_suspended = 1'b0;
    logic req_prog, req_dprog, req_erase, req_suspend, req_resume;
    logic [AW-1:0] req_addr, req_addr2;
    logic [DW-1:0] req_data, req_data2, aux_word;
    logic [1:0] rd_sel;
    logic [7:0] status_byte;

    int n_prog = 0, n_dprog = 0, n_erase = 0, n_susp = 0, n_res = 0;
    int checks = 0, errors = 0;
    bit done = 1'b0;

    typedef struct {
        string       tag;
        int          sel;
        int unsigned exp;
    } item_t;
    item_t exp_q[$];

    always #2.5 clk = ~clk;

    flash_cmd_decoder #(.AW(AW), .DW(DW), .MFR_CODE(MFR), .DEV_CODE(DEV)) uut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .wdata(wdata), .pe_busy(pe_busy), .pe_suspended(pe_suspended),
        .req_prog(req_prog), .req_dprog(req_dprog), .req_erase(req_erase),
        .req_suspend(req_suspend), .req_resume(req_resume),
        .req_addr(req_addr), .req_data(req_data), .req_addr2(req_addr2),
        .req_data2(req_data2), .rd_sel(rd_sel), .status_byte(status_byte),
        .aux_word(aux_word)
    );

    always @(posedge clk) begin
        if (req_prog)    n_prog  <= n_prog + 1;
        if (req_dprog)   n_dprog <= n_dprog + 1;
        if (req_erase)   n_erase <= n_erase + 1;
        if (req_suspend) n_susp  <= n_susp + 1;
        if (req_resume)  n_res   <= n_res + 1;
    end

    function automatic int unsigned observe(int sel);
        case (sel)
            SEL_RDSEL:  return int'(rd_sel);
            SEL_STAT:   return int'(status_byte);
            SEL_AUX:    return int'(aux_word);
            SEL_NPROG:  return n_prog;
            SEL_NDPROG: return n_dprog;
            SEL_NERASE: return n_erase;
            SEL_NSUSP:  return n_susp;
            SEL_NRES:   return n_res;
            SEL_ADDR:   return int'(req_addr);
            SEL_DATA:   return int'(req_data);
            SEL_ADDR2:  return int'(req_addr2);
            default:    return int'(req_data2);
        endcase
    endfunction

    // monitor: compares queued expectations between edges
    initial begin
        forever begin
            @(posedge clk);
            #2;
            while (exp_q.size() > 0) begin
                item_t it;
                int unsigned act;
                it  = exp_q.pop_front();
                act = observe(it.sel);
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual=%0h expected=%0h", it.tag, act, it.exp);
                end
            end
        end
    end

    task automatic expect_val(input string tag, input int sel, input int unsigned exp);
        item_t it;
        it.tag = tag; it.sel = sel; it.exp = exp;
        exp_q.push_back(it);
    endtask

    task automatic settle();
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input bit oe_low = 1'b0);
        @(negedge clk);
        ce_n = 1'b0; we_n = 1'b0; oe_n = oe_low ? 1'b0 : 1'b1;
        addr = a; wdata = d;
        @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        @(negedge clk);
        @(negedge clk);
    endtask

    task automatic set_ctl(input logic busy, input logic susp);
        @(negedge clk);
        pe_busy = busy; pe_suspended = susp;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        expect_val("R11 reset rd_sel", SEL_RDSEL, 0);
        expect_val("R12 reset status", SEL_STAT, 8'h80);
        settle();

        // R2 / R3 read mode selection
        bus_write(0, 16'h0070); expect_val("R2 70h", SEL_RDSEL, 1);
        expect_val("R12 status word", SEL_AUX, 16'h0080); settle();
        bus_write(0, 16'hAB90); expect_val("R2 90h", SEL_RDSEL, 2); settle();
        @(negedge clk); addr = 20'h00000;
        expect_val("R3 manufacturer", SEL_AUX, {8'h00, MFR}); settle();
        addr = 20'h00001;
        expect_val("R3 device", SEL_AUX, {8'h00, DEV}); settle();
        bus_write(0, 16'h0098); expect_val("R2 98h", SEL_RDSEL, 3); settle();
        bus_write(0, 16'h00FF); expect_val("R2 FFh", SEL_RDSEL, 0); settle();

        // R1 cycle with output enable low is not a write
        bus_write(0, 16'h0070, 1'b1); expect_val("R1 oe low ignored", SEL_RDSEL, 0); settle();

        // R4 erase
        bus_write(0, 16'h0020);
        bus_write(20'h4A5C3, 16'h00D0);
        expect_val("R4 erase count", SEL_NERASE, 1);
        expect_val("R4 erase addr", SEL_ADDR, 20'h4A5C3);
        expect_val("R4 status mode", SEL_RDSEL, 1); settle();

        // R8 busy
        set_ctl(1'b1, 1'b0);
        expect_val("R12 busy status", SEL_STAT, 8'h00);
        bus_write(0, 16'h00FF);
        expect_val("R8 busy rd_sel", SEL_RDSEL, 1); settle();
        set_ctl(1'b0, 1'b0);
        expect_val("R8 dropped FFh", SEL_RDSEL, 1); settle();
        set_ctl(1'b1, 1'b0);
        bus_write(0, 16'h00B0);
        expect_val("R8 suspend", SEL_NSUSP, 1); settle();

        // R9 erase suspended: program allowed
        set_ctl(1'b0, 1'b1);
        expect_val("R12 erase suspended", SEL_STAT, 8'hC0); settle();
        bus_write(0, 16'h0040);
        bus_write(20'h00777, 16'h1234);
        expect_val("R9 program in erase suspend", SEL_NPROG, 1);
        expect_val("R6 prog addr", SEL_ADDR, 20'h00777);
        expect_val("R6 prog data", SEL_DATA, 16'h1234); settle();
        set_ctl(1'b1, 1'b1);
        expect_val("R12 nested busy", SEL_STAT, 8'h40); settle();
        set_ctl(1'b0, 1'b1);
        bus_write(0, 16'h00D0);
        expect_val("R9 resume", SEL_NRES, 1); settle();
        set_ctl(1'b0, 1'b0);

        // R9 program suspended: program refused
        bus_write(0, 16'h0040);
        bus_write(20'h00888, 16'hBEEF);
        expect_val("R6 program", SEL_NPROG, 2); settle();
        set_ctl(1'b1, 1'b0);
        bus_write(0, 16'h00B0);
        expect_val("R8 suspend program", SEL_NSUSP, 2); settle();
        set_ctl(1'b0, 1'b1);
        expect_val("R12 program suspended", SEL_STAT, 8'h84); settle();
        bus_write(0, 16'h0040);
        bus_write(20'h00999, 16'hFFFF);
        expect_val("R9 no program in program suspend", SEL_NPROG, 2);
        expect_val("R9 FFh in suspend", SEL_RDSEL, 0); settle();
        bus_write(0, 16'h0090);
        expect_val("R9 signature in suspend", SEL_RDSEL, 2); settle();
        bus_write(0, 16'h00D0);
        expect_val("R9 resume program", SEL_NRES, 2);
        expect_val("R9 resume mode", SEL_RDSEL, 1); settle();
        set_ctl(1'b0, 1'b0);

        // R5 refused erase confirm
        bus_write(0, 16'h0020);
        bus_write(20'h00123, 16'h00FF);
        expect_val("R5 error bits", SEL_STAT, 8'hB0);
        expect_val("R5 array mode", SEL_RDSEL, 0);
        expect_val("R5 no erase", SEL_NERASE, 1); settle();
        bus_write(0, 16'h0050);
        expect_val("R5 clear", SEL_STAT, 8'h80); settle();

        // R7 double word
        bus_write(0, 16'h0030);
        bus_write(20'h00100, 16'hAAAA);
        bus_write(20'h00101, 16'h5555);
        expect_val("R7 dprog count", SEL_NDPROG, 1);
        expect_val("R7 addr1", SEL_ADDR, 20'h00100);
        expect_val("R7 data1", SEL_DATA, 16'hAAAA);
        expect_val("R7 addr2", SEL_ADDR2, 20'h00101);
        expect_val("R7 data2", SEL_DATA2, 16'h5555);
        expect_val("R7 status mode", SEL_RDSEL, 1); settle();
        bus_write(0, 16'h0030);
        bus_write(20'h00200, 16'h0001);
        bus_write(20'h00203, 16'h0002);
        expect_val("R7 bad pair refused", SEL_NDPROG, 1);
        expect_val("R7 bad pair array", SEL_RDSEL, 0); settle();

        // R6 alternative set-up
        bus_write(0, 16'h0010);
        bus_write(20'h00321, 16'h0F0F);
        expect_val("R6 alt program", SEL_NPROG, 3);
        expect_val("R6 alt addr", SEL_ADDR, 20'h00321); settle();

        // R10 invalid bytes
        bus_write(0, 16'h0070);
        bus_write(0, 16'h0060);
        expect_val("R10 invalid 60h", SEL_RDSEL, 0); settle();
        bus_write(0, 16'h0070);
        bus_write(0, 16'h00B0);
        expect_val("R10 idle B0h", SEL_RDSEL, 0);
        expect_val("R10 no suspend", SEL_NSUSP, 2); settle();

        // R11 reset discards partial sequence
        bus_write(0, 16'h0020);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); @(negedge clk); rst_n = 1'b1;
        bus_write(20'h00555, 16'h00D0);
        expect_val("R11 sequence dropped", SEL_NERASE, 1);
        expect_val("R11 array mode", SEL_RDSEL, 0); settle();

        settle();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule